// File: doc/BRIEF.md
# Hypervisor guest status register

This block is the control/status register that a hypervisor uses to hold and steer the state of a virtualized guest. Software reads and writes it through a simple CSR port. Each field of a write is legalized on its own instead of being stored raw. Three fields are also written by hardware on every trap into the hypervisor-supervisor level. These are the previous-virtualization flag, the previous-virtual-privilege bit and the guest-virtual-address flag. All other fields are driven straight out to the rest of the core as control bits.

Several parameters set the configuration. These are the register width, the number of guest external interrupt sources, and whether the guest XLEN and guest endianness are writable or hardwired. The trap cause is reduced to a single flag, which tells the block whether a guest virtual address was recorded. In the default configuration the register is 64 bits wide, the guest XLEN is writable, the guest endianness is hardwired to little (0) and there are 5 guest interrupt sources.

Top module: `guest_ctl_csr`

## Requirements
- R1: After reset, the guest XLEN field reads 1 in the default configuration, and every other field reads 0.
- R2: The read layout is fixed. Guest XLEN is at bits 33:32, trap-SRET at bit 22, trap-WFI at bit 21, trap-VM at bit 20, interrupt select at bits 17:12, hypervisor-in-user at bit 9, previous virtual privilege at bit 8, previous virtualization at bit 7, guest-virtual-address at bit 6 and guest big-endian at bit 5. Every other bit reads 0.
- R3: A software write with no trap in the same cycle stores the written bit into each of these fields: trap-SRET, trap-WFI, trap-VM, hypervisor-in-user, previous virtual privilege, previous virtualization and guest-virtual-address. The new value is visible after the clock edge.
- R4: A guest XLEN write is accepted only when bit 33 is 0 and bit 32 is not below the supervisor width input (0 means 32, 1 means 64). Otherwise the old value is kept.
- R5: An interrupt-select write is accepted only when the value is at most the configured number of sources (5 by default). Otherwise the old value is kept.
- R6: A trap loads the previous-virtualization bit with the from-guest input and the guest-virtual-address bit with the address flag input.
- R7: A trap taken from a guest mode loads the previous-virtual-privilege bit with the interrupted privilege input. A trap taken from a non-guest mode leaves that bit unchanged.
- R8: When a trap and a software write occur in the same cycle, the whole write is discarded, and only the fields named in R6 and R7 change.
- R9: In a cycle with neither a write nor a trap, no field changes. In particular, nothing clears the previous-virtual-privilege bit when the trap returns.
- R10: When guest endianness is hardwired (the default), the big-endian bit reads the fixed value 0 and ignores writes.
- R11: Each control output equals the field of the same name in the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csrWrEn | input | 1 | Software write strobe |
| csrWrData | input | XLEN | Software write value |
| supWide | input | 1 | Supervisor XLEN encoding (0 = 32, 1 = 64) |
| trapEn | input | 1 | Trap taken into the hypervisor-supervisor level this cycle |
| trapFromVirt | input | 1 | Interrupted mode was a guest mode (VS or VU) |
| trapPriorPriv | input | 1 | Nominal privilege of the interrupted guest mode (1 = supervisor) |
| trapGva | input | 1 | Trap recorded a guest virtual address |
| csrRdData | output | XLEN | Register read value |
| ctlGuestXl | output | 2 | Guest XLEN encoding |
| ctlTrapSret | output | 1 | Trap guest SRET |
| ctlTrapWfi | output | 1 | Trap guest WFI |
| ctlTrapVm | output | 1 | Trap guest address-translation operations |
| ctlIntSel | output | 6 | Guest external interrupt select |
| ctlHypUser | output | 1 | Hypervisor loads/stores allowed in user mode |
| ctlPrevPriv | output | 1 | Previous virtual privilege |
| ctlPrevVirt | output | 1 | Previous virtualization mode |
| ctlGva | output | 1 | Guest virtual address flag |
| ctlGuestBe | output | 1 | Guest data big-endian |

## Verification
The interrupt-select field is swept through all 64 values, which separates the accepted range from the rejected range exactly at the source count. Guest XLEN writes cover every requested encoding against both supervisor widths and both prior values, which tells rejection by the upper bit apart from rejection by being too narrow. The seven plain bits are written in all 128 combinations, which exposes swapped or stuck positions. Traps are driven with every combination of from-guest, privilege and address flag, both alone and together with a conflicting write, which tells the trap-wins rule and the unchanged-privilege case apart from ordinary stores.

// File: rtl/guest_csr_pkg.sv
package guest_csr_pkg;
  // Bit positions in the read/write word
  localparam int POS_XL   = 32;
  localparam int POS_SRET = 22;
  localparam int POS_WFI  = 21;
  localparam int POS_VM   = 20;
  localparam int POS_SEL  = 12;
  localparam int SEL_W    = 6;
  localparam int POS_HU   = 9;
  localparam int POS_PRIV = 8;
  localparam int POS_VIRT = 7;
  localparam int POS_GVA  = 6;
  localparam int POS_BE   = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrPlain;   // store the directly written bits
    logic wrXl;      // store the guest XLEN field
    logic wrSel;     // store the interrupt select field
    logic wrBe;      // store the endianness bit
    logic trapTake;  // hardware trap update
    logic trapVirt;  // trap came from a guest mode
  } guest_strobe_t;
endpackage

// File: rtl/guest_csr_ctrl.sv
module guest_csr_ctrl
  import guest_csr_pkg::*;
#(
  parameter int NUM_GEXT    = 5,
  parameter bit XL_WRITABLE = 1'b1,
  parameter bit BE_WRITABLE = 1'b0
) (
  input  logic             csrWrEn,
  input  logic             trapEn,
  input  logic             trapFromVirt,
  input  logic             supWide,
  input  logic [1:0]       reqXl,
  input  logic [SEL_W-1:0] reqSel,
  output guest_strobe_t    strb
);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_GEXT);

  logic wrOk;
  logic xlLegal;
  logic selLegal;

  // A trap in the same cycle discards the whole software write
  assign wrOk     = csrWrEn & ~trapEn;
  // Upper encoding bit is illegal; guest may not be narrower than supervisor
  assign xlLegal  = ~reqXl[1] & (reqXl[0] | ~supWide);
  assign selLegal = (reqSel <= SEL_MAX);

  always_comb begin
    strb          = '0;
    strb.wrPlain  = wrOk;
    strb.wrXl     = wrOk & xlLegal & XL_WRITABLE;
    strb.wrSel    = wrOk & selLegal;
    strb.wrBe     = wrOk & BE_WRITABLE;
    strb.trapTake = trapEn;
    strb.trapVirt = trapEn & trapFromVirt;
  end
endmodule

// File: rtl/guest_csr_data.sv
module guest_csr_data
  import guest_csr_pkg::*;
#(
  parameter int         XLEN        = 64,
  parameter bit         XL_WRITABLE = 1'b1,
  parameter logic [1:0] XL_VAL      = 2'd1,
  parameter bit         BE_WRITABLE = 1'b0,
  parameter bit         BE_VAL      = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  guest_strobe_t    strb,
  input  logic [XLEN-1:0]  wrData,
  input  logic [1:0]       reqXl,
  input  logic             trapPriorPriv,
  input  logic             trapGva,
  output logic [XLEN-1:0]  rdData,
  output logic [1:0]       guestXl,
  output logic             trapSret,
  output logic             trapWfi,
  output logic             trapVm,
  output logic [SEL_W-1:0] intSel,
  output logic             hypUser,
  output logic             prevPriv,
  output logic             prevVirt,
  output logic             gva,
  output logic             guestBe
);
  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  // Fields written by software, and for three of them by traps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapSret <= 1'b0;
      trapWfi  <= 1'b0;
      trapVm   <= 1'b0;
      intSel   <= '0;
      hypUser  <= 1'b0;
      prevPriv <= 1'b0;
      prevVirt <= 1'b0;
      gva      <= 1'b0;
    end else begin
      if (strb.wrPlain) begin
        trapSret <= wrData[POS_SRET];
        trapWfi  <= wrData[POS_WFI];
        trapVm   <= wrData[POS_VM];
        hypUser  <= wrData[POS_HU];
        prevPriv <= wrData[POS_PRIV];
        prevVirt <= wrData[POS_VIRT];
        gva      <= wrData[POS_GVA];
      end
      if (strb.wrSel) intSel <= wrData[POS_SEL +: SEL_W];
      if (strb.trapTake) begin
        prevVirt <= strb.trapVirt;
        gva      <= trapGva;
        if (strb.trapVirt) prevPriv <= trapPriorPriv;
      end
    end
  end

  // Guest XLEN: register or hardwired
  generate
    if (XL_WRITABLE) begin : g_xlReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          guestXl <= XL_VAL;
        else if (strb.wrXl) guestXl <= reqXl;
      end
    end else begin : g_xlFixed
      logic unusedXl;
      assign unusedXl = strb.wrXl ^ (^reqXl);
      assign guestXl  = (XLEN == 64) ? XL_VAL : 2'd0;
    end
  endgenerate

  // Guest endianness: register or hardwired
  generate
    if (BE_WRITABLE) begin : g_beReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          guestBe <= BE_VAL;
        else if (strb.wrBe) guestBe <= wrData[POS_BE];
      end
    end else begin : g_beFixed
      logic unusedBe;
      assign unusedBe = strb.wrBe;
      assign guestBe  = BE_VAL;
    end
  endgenerate

  // Read word assembly
  logic [31:0] lowWord;
  always_comb begin
    lowWord                  = '0;
    lowWord[POS_SRET]        = trapSret;
    lowWord[POS_WFI]         = trapWfi;
    lowWord[POS_VM]          = trapVm;
    lowWord[POS_SEL +: SEL_W] = intSel;
    lowWord[POS_HU]          = hypUser;
    lowWord[POS_PRIV]        = prevPriv;
    lowWord[POS_VIRT]        = prevVirt;
    lowWord[POS_GVA]         = gva;
    lowWord[POS_BE]          = guestBe;
  end

  generate
    if (XLEN == 64) begin : g_rd64
      assign rdData = {30'd0, guestXl, lowWord};
    end else begin : g_rd32
      assign rdData = lowWord;
    end
  endgenerate
endmodule

// File: rtl/guest_ctl_csr.sv
module guest_ctl_csr
  import guest_csr_pkg::*;
#(
  parameter int         XLEN     = 64,
  parameter int         NUM_GEXT = 5,
  parameter bit         XL_FIXED = 1'b0,
  parameter logic [1:0] XL_VAL   = 2'd1,
  parameter bit         BE_FIXED = 1'b1,
  parameter bit         BE_VAL   = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrWrEn,
  input  logic [XLEN-1:0] csrWrData,
  input  logic            supWide,
  input  logic            trapEn,
  input  logic            trapFromVirt,
  input  logic            trapPriorPriv,
  input  logic            trapGva,
  output logic [XLEN-1:0] csrRdData,
  output logic [1:0]      ctlGuestXl,
  output logic            ctlTrapSret,
  output logic            ctlTrapWfi,
  output logic            ctlTrapVm,
  output logic [5:0]      ctlIntSel,
  output logic            ctlHypUser,
  output logic            ctlPrevPriv,
  output logic            ctlPrevVirt,
  output logic            ctlGva,
  output logic            ctlGuestBe
);
  localparam bit XL_WRITABLE = (XLEN == 64) && !XL_FIXED;
  localparam bit BE_WRITABLE = !BE_FIXED;

  guest_strobe_t strb;
  logic [1:0]    reqXl;

  generate
    if (XLEN == 64) begin : g_req64
      assign reqXl = csrWrData[POS_XL +: 2];
    end else begin : g_req32
      assign reqXl = 2'd0;
    end
  endgenerate

  guest_csr_ctrl #(
    .NUM_GEXT   (NUM_GEXT),
    .XL_WRITABLE(XL_WRITABLE),
    .BE_WRITABLE(BE_WRITABLE)
  ) u_ctrl (
    .csrWrEn     (csrWrEn),
    .trapEn      (trapEn),
    .trapFromVirt(trapFromVirt),
    .supWide     (supWide),
    .reqXl       (reqXl),
    .reqSel      (csrWrData[POS_SEL +: SEL_W]),
    .strb        (strb)
  );

  guest_csr_data #(
    .XLEN       (XLEN),
    .XL_WRITABLE(XL_WRITABLE),
    .XL_VAL     (XL_VAL),
    .BE_WRITABLE(BE_WRITABLE),
    .BE_VAL     (BE_VAL)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (csrWrData),
    .reqXl        (reqXl),
    .trapPriorPriv(trapPriorPriv),
    .trapGva      (trapGva),
    .rdData       (csrRdData),
    .guestXl      (ctlGuestXl),
    .trapSret     (ctlTrapSret),
    .trapWfi      (ctlTrapWfi),
    .trapVm       (ctlTrapVm),
    .intSel       (ctlIntSel),
    .hypUser      (ctlHypUser),
    .prevPriv     (ctlPrevPriv),
    .prevVirt     (ctlPrevVirt),
    .gva          (ctlGva),
    .guestBe      (ctlGuestBe)
  );
endmodule

// File: rtl/guest_ctl_csr_chk.sv
module guest_ctl_csr_chk
#(
  parameter int         XLEN     = 64,
  parameter int         NUM_GEXT = 5,
  parameter bit         XL_FIXED = 1'b0,
  parameter bit         BE_FIXED = 1'b1,
  parameter bit         BE_VAL   = 1'b0
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrWrEn,
  input logic [XLEN-1:0] csrWrData,
  input logic            trapEn,
  input logic            trapFromVirt,
  input logic            trapPriorPriv,
  input logic            trapGva,
  input logic [XLEN-1:0] csrRdData,
  input logic [1:0]      ctlGuestXl,
  input logic            ctlTrapSret,
  input logic            ctlTrapWfi,
  input logic            ctlTrapVm,
  input logic [5:0]      ctlIntSel,
  input logic            ctlHypUser,
  input logic            ctlPrevPriv,
  input logic            ctlPrevVirt,
  input logic            ctlGva,
  input logic            ctlGuestBe
);
  localparam logic [5:0] SEL_MAX = 6'(NUM_GEXT);

  assert_sel_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctlIntSel <= SEL_MAX);

  assert_trap_virt_gva_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapEn |=> (ctlPrevVirt == $past(trapFromVirt)) && (ctlGva == $past(trapGva)));

  assert_trap_guest_priv_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trapEn && trapFromVirt) |=> ctlPrevPriv == $past(trapPriorPriv));

  assert_trap_host_keeps_priv_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trapEn && !trapFromVirt) |=> $stable(ctlPrevPriv));

  assert_trap_drops_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    trapEn |=> $stable(ctlTrapSret) && $stable(ctlTrapWfi) && $stable(ctlTrapVm) &&
               $stable(ctlIntSel) && $stable(ctlHypUser) && $stable(ctlGuestXl) &&
               $stable(ctlGuestBe));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!csrWrEn && !trapEn) |=> $stable(csrRdData));

  assert_outputs_match_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ctlTrapSret == csrRdData[22]) && (ctlTrapWfi == csrRdData[21]) &&
    (ctlTrapVm == csrRdData[20]) && (ctlIntSel == csrRdData[17:12]) &&
    (ctlHypUser == csrRdData[9]) && (ctlPrevPriv == csrRdData[8]) &&
    (ctlPrevVirt == csrRdData[7]) && (ctlGva == csrRdData[6]) &&
    (ctlGuestBe == csrRdData[5]));

  generate
    if (XLEN == 64 && !XL_FIXED) begin : g_xlChk
      assert_xl_upper_rejected_R4: assert property (@(posedge clk) disable iff (!rstN)
        (csrWrEn && !trapEn && csrWrData[33]) |=> $stable(ctlGuestXl));
      assert_xl_read_R11: assert property (@(posedge clk) disable iff (!rstN)
        ctlGuestXl == csrRdData[33:32]);
    end
    if (BE_FIXED) begin : g_beChk
      assert_be_hardwired_R10: assert property (@(posedge clk) disable iff (!rstN)
        ctlGuestBe == BE_VAL);
    end
  endgenerate
endmodule

bind guest_ctl_csr guest_ctl_csr_chk #(
  .XLEN    (XLEN),
  .NUM_GEXT(NUM_GEXT),
  .XL_FIXED(XL_FIXED),
  .BE_FIXED(BE_FIXED),
  .BE_VAL  (BE_VAL)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .csrWrEn      (csrWrEn),
  .csrWrData    (csrWrData),
  .trapEn       (trapEn),
  .trapFromVirt (trapFromVirt),
  .trapPriorPriv(trapPriorPriv),
  .trapGva      (trapGva),
  .csrRdData    (csrRdData),
  .ctlGuestXl   (ctlGuestXl),
  .ctlTrapSret  (ctlTrapSret),
  .ctlTrapWfi   (ctlTrapWfi),
  .ctlTrapVm    (ctlTrapVm),
  .ctlIntSel    (ctlIntSel),
  .ctlHypUser   (ctlHypUser),
  .ctlPrevPriv  (ctlPrevPriv),
  .ctlPrevVirt  (ctlPrevVirt),
  .ctlGva       (ctlGva),
  .ctlGuestBe   (ctlGuestBe)
);

// File: tb/guest_ctl_csr_tb.sv
`timescale 1ns/100ps
module guest_ctl_csr_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [63:0] csrWrData = '0;
  logic        supWide = 1'b0;
  logic        trapEn = 1'b0;
  logic        trapFromVirt = 1'b0;
  logic        trapPriorPriv = 1'b0;
  logic        trapGva = 1'b0;
  logic [63:0] csrRdData;
  logic [1:0]  ctlGuestXl;
  logic        ctlTrapSret, ctlTrapWfi, ctlTrapVm;
  logic [5:0]  ctlIntSel;
  logic        ctlHypUser, ctlPrevPriv, ctlPrevVirt, ctlGva, ctlGuestBe;

  int nChecks = 0;
  int nFails  = 0;

  // Bench model of the fields
  logic [1:0] mXl = 2'd1;
  logic       mSret = 0, mWfi = 0, mVm = 0, mHu = 0, mPriv = 0, mVirt = 0, mGva = 0;
  logic [5:0] mSel = '0;
  localparam int NUM_SRC = 5;

  always #2.5 clk = ~clk;

  guest_ctl_csr u_dut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .supWide(supWide), .trapEn(trapEn), .trapFromVirt(trapFromVirt),
    .trapPriorPriv(trapPriorPriv), .trapGva(trapGva), .csrRdData(csrRdData),
    .ctlGuestXl(ctlGuestXl), .ctlTrapSret(ctlTrapSret), .ctlTrapWfi(ctlTrapWfi),
    .ctlTrapVm(ctlTrapVm), .ctlIntSel(ctlIntSel), .ctlHypUser(ctlHypUser),
    .ctlPrevPriv(ctlPrevPriv), .ctlPrevVirt(ctlPrevVirt), .ctlGva(ctlGva),
    .ctlGuestBe(ctlGuestBe)
  );

  function automatic logic [63:0] expRd();
    return {30'd0, mXl, 9'd0, mSret, mWfi, mVm, 2'd0, mSel, 2'd0,
            mHu, mPriv, mVirt, mGva, 1'b0, 5'd0};
  endfunction

  function automatic logic [15:0] expOut();
    return {mXl, mSret, mWfi, mVm, mSel, mHu, mPriv, mVirt, mGva, 1'b0};
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Full comparison of read word and control outputs against the model
  task automatic checkAll(input string req);
    check(req,
      {csrRdData, ctlGuestXl, ctlTrapSret, ctlTrapWfi, ctlTrapVm, ctlIntSel,
       ctlHypUser, ctlPrevPriv, ctlPrevVirt, ctlGva, ctlGuestBe},
      {expRd(), expOut()});
  endtask

  // One cycle of stimulus, then model update; sampling at the following negedge
  task automatic step(input logic we, input logic [63:0] d, input logic te,
                      input logic fv, input logic pp, input logic g);
    @(negedge clk);
    csrWrEn = we; csrWrData = d; trapEn = te;
    trapFromVirt = fv; trapPriorPriv = pp; trapGva = g;
    @(negedge clk);
    csrWrEn = 1'b0; trapEn = 1'b0;
    if (te) begin
      mVirt = fv;
      mGva  = g;
      if (fv) mPriv = pp;
    end else if (we) begin
      mSret = d[22]; mWfi = d[21]; mVm = d[20];
      mHu = d[9]; mPriv = d[8]; mVirt = d[7]; mGva = d[6];
      if (int'(d[17:12]) <= NUM_SRC) mSel = d[17:12];
      if (!d[33] && (d[32] || !supWide)) mXl = d[33:32];
    end
  endtask

  function automatic logic [63:0] plainWord(input logic [6:0] p);
    logic [63:0] w = '0;
    w[22] = p[6]; w[21] = p[5]; w[20] = p[4];
    w[9] = p[3]; w[8] = p[2]; w[7] = p[1]; w[6] = p[0];
    return w;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    logic [63:0] keepWord;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // R2/R10: all ones, illegal select and XLEN rejected, unlisted bits zero
    step(1'b1, '1, 1'b0, 1'b0, 1'b0, 1'b0);
    checkAll("R2 all-ones write");
    check("R2 unlisted bits zero", {16'd0, csrRdData & ~64'h0000_0003_0073_F3E0}, 80'd0);
    check("R10 endianness hardwired", {79'd0, ctlGuestBe}, 80'd0);

    // R10: write only the endianness bit
    step(1'b1, 64'h0000_0001_0000_0020, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 be write ignored", {79'd0, csrRdData[5]}, 80'd0);

    // R3: all plain-bit patterns
    for (int p = 0; p < 128; p++) begin
      step(1'b1, plainWord(7'(p)) | 64'h0000_0001_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
      checkAll("R3 plain bits");
    end

    // R5: select sweep, alternating with a legal value
    for (int v = 0; v < 64; v++) begin
      step(1'b1, 64'h0000_0001_0000_3000, 1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 64'h0000_0001_0000_0000 | (64'(v) << 12), 1'b0, 1'b0, 1'b0, 1'b0);
      checkAll("R5 select legalization");
    end

    // R4: XLEN requests against both supervisor widths and both prior values
    for (int s = 0; s < 2; s++) begin
      for (int st = 0; st < 2; st++) begin
        for (int r = 0; r < 4; r++) begin
          supWide = 1'b0;
          step(1'b1, 64'(st) << 32, 1'b0, 1'b0, 1'b0, 1'b0);
          supWide = s[0];
          step(1'b1, 64'(r) << 32, 1'b0, 1'b0, 1'b0, 1'b0);
          checkAll("R4 guest XLEN legalization");
        end
      end
    end
    supWide = 1'b0;

    // R6/R7: trap alone, every input combination from both prior states
    for (int st = 0; st < 4; st++) begin
      for (int c = 0; c < 8; c++) begin
        step(1'b1, plainWord({4'b1010, st[0], st[1], st[0]}) | 64'h0000_0001_0000_2000,
             1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, c[2], c[1], c[0]);
        checkAll(c[2] ? "R7 trap from guest" : "R7 trap from host");
        check("R6 trap virt and gva", {78'd0, ctlPrevVirt, ctlGva}, {78'd0, c[2], c[0]});
      end
    end

    // R8: trap and conflicting write together
    for (int c = 0; c < 8; c++) begin
      step(1'b1, 64'h0000_0001_0000_4000, 1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b1, ~64'h0000_0001_0000_4000 & 64'h0000_0000_0073_F3E0 | 64'h0000_0000_0000_1000,
           1'b1, c[2], c[1], c[0]);
      checkAll("R8 trap wins over write");
    end

    // R9: idle cycles with wiggling inputs leave every field in place
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1);
    keepWord = csrRdData;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, {32'hFFFF_FFFF, 32'(i * 32'h1357_9BDF)}, 1'b0, i[0], i[1], i[2]);
      check("R9 hold without write or trap", {16'd0, csrRdData}, {16'd0, keepWord});
    end
    check("R9 prev privilege still set", {79'd0, ctlPrevPriv}, {79'd0, 1'b1});
    checkAll("R11 outputs after hold");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule